// File: doc/BRIEF.md
# Four-Channel Range-Stepped PWM Generator

This block produces four independent pulse-width-modulated outputs. Each channel is set up through a byte-wide register write port. Software chooses a frequency from a two-bit range selector and a six-bit multiplier. It also sets a duty byte that splits every period into 256 slots, an inversion flag and an enable flag.

A free-running timebase strobe (`tick_en`) advances one phase accumulator per channel. On every strobe, each accumulator adds an increment equal to (multiplier + 1) shifted left by twice the range selector. The upper eight accumulator bits form the slot index. This gives base steps of 0.5, 2, 8 and 32 frequency units, each four times the previous one, for a span of 0.5 to 2048 units when the strobe runs at 2^ACC_W × 0.5 units.

Configuration writes are applied at once. The accumulators are never cleared or realigned by a write, so a period that straddles a write can be a mix of the old and new settings.

Top module: `steppwm_top`

## Requirements
- R1: Four channels, numbered 0 to 3, are configured through these registers. The frequency byte of channel n is at address 0x08+n, and its duty byte is at 0x0C+n. The inversion flag of channel n is bit n of address 0x05. The enable flag of channel n is bit 4+n of address 0x07.
- R2: In a frequency byte, bits 7:6 select the range r and bits 5:0 hold the multiplier c. Each `tick_en` pulse adds (c+1)<<(2r) to the channel accumulator, modulo 2^ACC_W. The output period is therefore 2^ACC_W/((c+1)<<(2r)) strobes.
- R3: Before inversion, a channel is high while its slot index (the top 8 accumulator bits) is at most its duty byte d. Starting from a zero accumulator with a power-of-two increment inc, the high time is ceil((d+1)·2^(ACC_W-8)/inc) strobes. Duty 0 still yields one slot high, so a 0 % output cannot be produced.
- R4: An enabled, non-inverted channel with duty byte 0xFF stays high continuously.
- R5: When the inversion flag is set, the channel waveform is complemented. The high time becomes the period minus the non-inverted high time.
- R6: A channel whose enable flag is clear drives 0 from the next clock on, whatever its inversion flag.
- R7: A write to a frequency, duty or inversion register does not clear or realign the accumulator. After a duty write, rising edges keep the same spacing from the edge before the write.
- R8: While `tick_en` is low, the accumulators hold their values and the outputs stay constant.
- R9: While reset is asserted, and after it is released, all registers read as zero, every channel is disabled and every output is low.
- R10: Writes to any address outside 0x05, 0x07 and 0x08..0x0F change no register. The same holds for bits 7:4 of 0x05 and bits 3:0 of 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| tick_en | input | 1 | Timebase strobe; each high cycle advances every accumulator once |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | NCH | Registered channel outputs |

## Verification
Some properties are checked by the bound assertions on every cycle: a disabled channel drives low, full duty without inversion stays high, the accumulators freeze while the strobe is low, stray writes leave the register file untouched, and outputs are low during reset. Other behaviours only the bench scenarios can show: the period and high-time formulas for each range, inversion turning high time into its complement, the one-slot minimum duty, and rising-edge spacing surviving a mid-period duty write. These need whole periods to be measured at the pins.

// File: rtl/steppwm_pkg.sv
package steppwm_pkg;

  // Register map (channel index is added to the base addresses)
  localparam logic [7:0] ADDR_POL   = 8'h05;
  localparam logic [7:0] ADDR_EN    = 8'h07;
  localparam logic [7:0] ADDR_FREQ0 = 8'h08;
  localparam logic [7:0] ADDR_DUTY0 = 8'h0C;

  // Enable flags start at this bit of the enable register
  localparam int unsigned EN_LSB = 4;

  // Slot index width: 256 slots per period
  localparam int unsigned SLOT_W = 8;

  // Multiplier field width inside a frequency byte
  localparam int unsigned CNT_W = 6;

  typedef struct packed {
    logic [1:0]       rng;
    logic [CNT_W-1:0] cnt;
  } freq_code_t;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_POL,
    WR_EN,
    WR_FREQ,
    WR_DUTY
  } wr_kind_t;

endpackage

// File: rtl/steppwm_regs.sv
module steppwm_regs
  import steppwm_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                wr_addr,
  input  logic [7:0]                wr_data,
  output freq_code_t [NCH-1:0]      freq_q,
  output logic [NCH-1:0][7:0]       duty_q,
  output logic [NCH-1:0]            pol_q,
  output logic [NCH-1:0]            en_q
);

  localparam int unsigned IDX_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [8:0]  FREQ_END = {1'b0, ADDR_FREQ0} + 9'(NCH);
  localparam logic [8:0]  DUTY_END = {1'b0, ADDR_DUTY0} + 9'(NCH);

  wr_kind_t              kind;
  logic [IDX_W-1:0]      idx;
  freq_code_t [NCH-1:0]  freq_d;
  logic [NCH-1:0][7:0]   duty_d;
  logic [NCH-1:0]        pol_d;
  logic [NCH-1:0]        en_d;

  // Address decode: classify the write and extract the channel index
  always_comb begin
    kind = WR_NONE;
    idx  = '0;
    if (wr_en) begin
      if (wr_addr == ADDR_POL) begin
        kind = WR_POL;
      end else if (wr_addr == ADDR_EN) begin
        kind = WR_EN;
      end else if (wr_addr >= ADDR_FREQ0 && {1'b0, wr_addr} < FREQ_END) begin
        kind = WR_FREQ;
        idx  = IDX_W'(wr_addr - ADDR_FREQ0);
      end else if (wr_addr >= ADDR_DUTY0 && {1'b0, wr_addr} < DUTY_END) begin
        kind = WR_DUTY;
        idx  = IDX_W'(wr_addr - ADDR_DUTY0);
      end
    end
  end

  // Next-state of the register file
  always_comb begin
    freq_d = freq_q;
    duty_d = duty_q;
    pol_d  = pol_q;
    en_d   = en_q;
    unique case (kind)
      WR_POL:  pol_d       = wr_data[NCH-1:0];
      WR_EN:   en_d        = wr_data[EN_LSB +: NCH];
      WR_FREQ: freq_d[idx] = freq_code_t'(wr_data);
      WR_DUTY: duty_d[idx] = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      duty_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (kind != WR_NONE) begin
      freq_q <= freq_d;
      duty_q <= duty_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/steppwm_incdec.sv
module steppwm_incdec
  import steppwm_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  freq_code_t        code,
  output logic [ACC_W-1:0]  inc
);

  localparam int unsigned MW = CNT_W + 1;

  logic [MW-1:0] mult;
  logic [2:0]    shamt;

  // increment = (multiplier + 1) * 4^range
  always_comb begin
    mult  = {1'b0, code.cnt} + MW'(1);
    shamt = {code.rng, 1'b0};
    inc   = ACC_W'(mult) << shamt;
  end

endmodule

// File: rtl/steppwm_chan.sv
module steppwm_chan
  import steppwm_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  freq_code_t        freq,
  input  logic [7:0]        duty,
  input  logic              pol,
  input  logic              en,
  output logic [ACC_W-1:0]  acc_q,
  output logic              pwm_q
);

  logic [ACC_W-1:0]  inc;
  logic [ACC_W-1:0]  acc_d;
  logic [SLOT_W-1:0] slot;
  logic              raw;
  logic              shaped;
  logic              pwm_d;

  steppwm_incdec #(.ACC_W(ACC_W)) u_incdec (
    .code (freq),
    .inc  (inc)
  );

  // Compare, then invert, then gate
  always_comb begin
    acc_d  = acc_q + inc;
    slot   = acc_q[ACC_W-1 -: SLOT_W];
    raw    = (slot <= duty);
    shaped = raw ^ pol;
    pwm_d  = en & shaped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tick_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

endmodule

// File: rtl/steppwm_top.sv
module steppwm_top
  import steppwm_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned ACC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [NCH-1:0]  pwm_out
);

  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  freq_code_t [NCH-1:0]        freq_q;
  logic [NCH-1:0][7:0]         duty_q;
  logic [NCH-1:0]              pol_q;
  logic [NCH-1:0]              en_q;
  logic [NCH-1:0][ACC_W-1:0]   acc_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  steppwm_regs #(.NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .freq_q  (freq_q),
    .duty_q  (duty_q),
    .pol_q   (pol_q),
    .en_q    (en_q)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      steppwm_chan #(.ACC_W(ACC_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .tick_en (tick_en),
        .freq    (freq_q[g]),
        .duty    (duty_q[g]),
        .pol     (pol_q[g]),
        .en      (en_q[g]),
        .acc_q   (acc_q[g]),
        .pwm_q   (pwm_out[g])
      );
    end
  endgenerate

endmodule

// File: rtl/steppwm_chk.sv
module steppwm_chk
  import steppwm_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned ACC_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_sync_n,
  input  logic                       tick_en,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_addr,
  input  freq_code_t [NCH-1:0]       freq_q,
  input  logic [NCH-1:0][7:0]        duty_q,
  input  logic [NCH-1:0]             pol_q,
  input  logic [NCH-1:0]             en_q,
  input  logic [NCH-1:0][ACC_W-1:0]  acc_q,
  input  logic [NCH-1:0]             pwm_out
);

  logic mapped;
  assign mapped = (wr_addr == ADDR_POL) || (wr_addr == ADDR_EN) ||
                  (wr_addr >= ADDR_FREQ0 && wr_addr <= 8'(ADDR_DUTY0 + NCH - 1));

  always @(posedge clk) begin
    if (!rst_sync_n) begin
      AST_RESET_LOW: assert (pwm_out == '0) else $error("output high in reset"); // R9
    end
  end

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !mapped) |=> ($stable(freq_q) && $stable(duty_q) && $stable(pol_q) && $stable(en_q)))
    else $error("unmapped write changed a register"); // R10

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !en_q[g] |=> !pwm_out[g])
        else $error("disabled channel %0d high", g); // R6

      AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (en_q[g] && !pol_q[g] && duty_q[g] == 8'hFF) |=> pwm_out[g])
        else $error("full duty channel %0d low", g); // R4

      AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !tick_en |=> $stable(acc_q[g]))
        else $error("accumulator %0d moved without tick", g); // R8
    end
  endgenerate

endmodule

bind steppwm_top steppwm_chk #(.NCH(NCH), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_en    (tick_en),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .freq_q     (freq_q),
  .duty_q     (duty_q),
  .pol_q      (pol_q),
  .en_q       (en_q),
  .acc_q      (acc_q),
  .pwm_out    (pwm_out)
);

// File: tb/tb_steppwm_top.sv
module tb_steppwm_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int ACC_W      = 16;
  localparam int WATCHDOG   = 200000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick_en;
  logic           wr_en;
  logic [7:0]     wr_addr;
  logic [7:0]     wr_data;
  logic [NCH-1:0] pwm_out;

  int     checks = 0;
  int     errors = 0;
  longint cyc    = 0;

  // Bench-side model of the programmed configuration
  int rng_m [NCH];
  int cnt_m [NCH];
  int duty_m[NCH];
  int pol_m [NCH];

  typedef struct {
    int    ch;
    int    per;
    int    hi;
    string req;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  steppwm_top #(.NCH(NCH), .ACC_W(ACC_W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int incr(input int ch);
    return (cnt_m[ch] + 1) << (2 * rng_m[ch]);
  endfunction

  function automatic int exp_period(input int ch);
    return (1 << ACC_W) / incr(ch);
  endfunction

  function automatic int exp_high(input int ch);
    int base;
    base = (((duty_m[ch] + 1) << (ACC_W - 8)) + incr(ch) - 1) / incr(ch);
    return (pol_m[ch] != 0) ? exp_period(ch) - base : base;
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Driver side: push an expected waveform and wait for the monitor
  task automatic expect_wave(input int ch, input string req);
    exp_t it;
    it.ch  = ch;
    it.per = exp_period(ch);
    it.hi  = exp_high(ch);
    it.req = req;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    per = 0;
    hi  = 0;
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
    while (pwm_out[ch]) begin hi++; per++; @(negedge clk); end
    while (!pwm_out[ch]) begin per++; @(negedge clk); end
  endtask

  task automatic wait_rise(input int ch);
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares them with measured waveforms
  initial begin : monitor
    forever begin : mon_loop
      exp_t it;
      int   per;
      int   hi;
      while (exp_q.size() == 0) @(negedge clk);
      it = exp_q[0];
      measure(it.ch, per, hi);
      check_eq(it.req, $sformatf("ch%0d period", it.ch), per, it.per);
      check_eq(it.req, $sformatf("ch%0d high time", it.ch), hi, it.hi);
      void'(exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual cycle %0d expected completion earlier", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    longint t1;
    longint t2;
    int     bad;
    logic [NCH-1:0] snap;

    rst_n   = 1'b0;
    tick_en = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    for (int i = 0; i < NCH; i++) begin
      rng_m[i] = 0; cnt_m[i] = 0; duty_m[i] = 0; pol_m[i] = 0;
    end

    repeat (3) @(negedge clk);
    check_eq("R9", "outputs during reset", pwm_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R9", "outputs after reset", pwm_out, 0);

    // R1 R2: program one range per channel while the timebase is stopped
    reg_write(8'h08, 8'h07); rng_m[0] = 0; cnt_m[0] = 7;
    reg_write(8'h09, 8'h43); rng_m[1] = 1; cnt_m[1] = 3;
    reg_write(8'h0A, 8'h8F); rng_m[2] = 2; cnt_m[2] = 15;
    reg_write(8'h0B, 8'hFF); rng_m[3] = 3; cnt_m[3] = 63;
    reg_write(8'h0C, 8'd3);  duty_m[0] = 3;
    reg_write(8'h0D, 8'd9);  duty_m[1] = 9;
    reg_write(8'h0E, 8'd99); duty_m[2] = 99;
    reg_write(8'h0F, 8'd40); duty_m[3] = 40;
    reg_write(8'h05, 8'h08); pol_m[3] = 1;
    check_eq("R6", "outputs before enable", pwm_out, 0);
    reg_write(8'h07, 8'hF0);
    repeat (3) @(negedge clk);
    // slot 0 with no tick: non-inverted channels high, inverted channel low
    check_eq("R8", "outputs frozen at slot zero", pwm_out, 4'b0111);
    snap = pwm_out;
    bad  = 0;
    repeat (50) begin @(negedge clk); if (pwm_out !== snap) bad++; end
    check_eq("R8", "changes with tick low", bad, 0);

    tick_en = 1'b1;
    expect_wave(2, "R1 R2 R3");
    expect_wave(3, "R1 R2 R5");
    expect_wave(1, "R1 R2 R3");
    expect_wave(0, "R1 R2 R3");

    // R7: a mid-period duty write keeps the rising-edge spacing
    wait_rise(2);
    t1 = cyc;
    reg_write(8'h0E, 8'd0); duty_m[2] = 0;
    wait_rise(2);
    t2 = cyc;
    check_eq("R7", "rise spacing across duty write", t2 - t1, exp_period(2));
    expect_wave(2, "R3 minimum duty");

    reg_write(8'h0E, 8'd200); duty_m[2] = 200;
    expect_wave(2, "R3");

    reg_write(8'h05, 8'h00); pol_m[3] = 0;
    expect_wave(3, "R5 cleared");
    reg_write(8'h0F, 8'd0); duty_m[3] = 0;
    expect_wave(3, "R3 coarse minimum");

    // R4: full duty
    reg_write(8'h0E, 8'hFF); duty_m[2] = 255;
    repeat (2) @(negedge clk);
    bad = 0;
    repeat (600) begin @(negedge clk); if (!pwm_out[2]) bad++; end
    check_eq("R4", "low samples at full duty", bad, 0);
    reg_write(8'h0E, 8'd99); duty_m[2] = 99;

    // R6: disabled channels low regardless of inversion
    reg_write(8'h05, 8'h0C); pol_m[2] = 1; pol_m[3] = 1;
    reg_write(8'h07, 8'h30);
    repeat (2) @(negedge clk);
    bad = 0;
    repeat (300) begin @(negedge clk); if (pwm_out[3:2] != 2'b00) bad++; end
    check_eq("R6", "high samples on disabled channels", bad, 0);

    // R10: stray writes and unused bits
    reg_write(8'h06, 8'hFF);
    reg_write(8'h04, 8'hFF);
    reg_write(8'h10, 8'hFF);
    reg_write(8'h00, 8'hFF);
    reg_write(8'h07, 8'h3F);
    repeat (2) @(negedge clk);
    bad = 0;
    repeat (300) begin @(negedge clk); if (pwm_out[3:2] != 2'b00) bad++; end
    check_eq("R10", "disabled channels after stray writes", bad, 0);
    expect_wave(1, "R10");

    reg_write(8'h05, 8'hF4); pol_m[3] = 0;
    reg_write(8'h07, 8'hF0);
    expect_wave(2, "R5 inverted");
    expect_wave(3, "R10 unused polarity bits");

    // R8: stop the timebase mid-run
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    snap = pwm_out;
    bad  = 0;
    repeat (200) begin @(negedge clk); if (pwm_out !== snap) bad++; end
    check_eq("R8", "changes with tick stopped", bad, 0);
    tick_en = 1'b1;
    expect_wave(3, "R8 resumed");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule